// File: doc/BRIEF.md
# Dual-Mode Max-Star / Check-Node Magnitude Cell

This cell is the shared arithmetic element of a decoder that serves both layered low-density parity-check decoding and convolutional turbo decoding. A mode input chooses the operation on one add, compare, select and correct datapath. In check-node mode the cell returns the magnitude of the pairwise soft-XOR of two log-likelihood ratios. It takes the smaller magnitude and adjusts it with two correction terms. In trellis mode it acts as an add-compare-select-add cell and returns the max-star of two branch-extended path metrics.

All values are signed fixed-point words with two fractional bits, so one unit is a quarter. The nonlinear term log(1+e^-|x|) is approximated by a four-level table. Two bypass inputs can remove individual correction terms. The result is registered once under a clock enable. The sign of a check-node result is the product of the operand signs and is handled by the surrounding logic, outside this cell.

Top module: `dfc_cell`

## Requirements
- R1: While reset is asserted, and after it is released until the first enabled edge, the result `z` is 0.
- R2: When `en` is 1 at a rising clock edge, `z` takes the new result, so it is visible one cycle after the operands. When `en` is 0, `z` keeps its value whatever the operands do.
- R3: The operand sums S1 = X+Y and S2 = V+W saturate to the signed 9-bit range [-256, 255].
- R4: The correction of an input d works on |d| in quarter units: 0 gives 3, 1 to 3 give 2, 4 to 8 give 1, and above 8 gives 0.
- R5: Trellis mode (sel=0, byp1=1, byp2=0) gives z = max(S1,S2) + corr(S1−S2).
- R6: Check-node mode (sel=1, byp1=0, byp2=1, X=V=|a|, Y=|b|, W=−|b|) gives z = base + corrU(S1) − corr(S2). The base is X when S2 is negative and Y otherwise. The result lies within [min(|a|,|b|)−3, min(|a|,|b|)].
- R7: The unsigned correction corrU applied to S1 is 0 for a negative S1 and equals corr(S1) otherwise.
- R8: In any control combination, z = base + (byp1 ? 0 : corrU(S1)) + (byp2 ? 0 : corr(S1−S2)) − (sel ? corr(S2) : 0). With sel=0 the base is S2 when S1<S2 and S1 otherwise.
- R9: The final sum saturates to [-256, 255] before it is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Result register enable |
| sel | input | 1 | 1 = check-node mode, 0 = trellis mode |
| byp1 | input | 1 | Removes the unsigned correction of S1 |
| byp2 | input | 1 | Removes the signed correction of S1−S2 |
| x | input | 9 | Operand X (signed) |
| y | input | 9 | Operand Y (signed) |
| v | input | 9 | Operand V (signed) |
| w | input | 9 | Operand W (signed) |
| z | output | 9 | Registered result (signed) |

## Verification
Each result is due exactly one clock edge after the operands and `en` are applied. The bench drives inputs on the falling edge, so the result from one falling-edge drive is compared at the next falling edge. A reference model keeps one expected value and updates it only for enabled drives, which also covers the hold behaviour when the enable is low. The checker's properties look one edge ahead with `|=>` to match this single register stage.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  // fractional bits of every value
  localparam int FRAC = 2;
  // correction thresholds on |d| (0.75 and 2.0)
  localparam int CORR_T_LO = (3 << FRAC) / 4;
  localparam int CORR_T_HI = 2 << FRAC;
  // correction levels (0.75, 0.5, 0.25)
  localparam int CORR_V0 = (3 << FRAC) / 4;
  localparam int CORR_V1 = (1 << FRAC) / 2;
  localparam int CORR_V2 = (1 << FRAC) / 4;
  localparam int CORR_W  = $clog2(CORR_V0 + 1);
endpackage

// File: rtl/dfc_sat_add.sv
module dfc_sat_add #(
  parameter int W = 9
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  logic [W:0] full;
  logic       ovf;

  always_comb begin
    full = {a[W-1], a} + {b[W-1], b};
    ovf  = full[W] ^ full[W-1];
    if (ovf) s = full[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else     s = full[W-1:0];
  end
endmodule

// File: rtl/dfc_corr_lut.sv
module dfc_corr_lut
  import dfc_pkg::*;
#(
  parameter int IW        = 9,
  parameter bit SIGNED_IN = 1'b1
) (
  input  logic [IW-1:0]     d,
  output logic [CORR_W-1:0] c
);
  localparam logic [IW:0] LIM_LO = (IW+1)'(CORR_T_LO);
  localparam logic [IW:0] LIM_HI = (IW+1)'(CORR_T_HI);

  logic [IW:0]       ext;
  logic [IW:0]       mag;
  logic [CORR_W-1:0] lvl;

  always_comb begin
    ext = {d[IW-1], d};
    mag = d[IW-1] ? (~ext + 1'b1) : ext;
    if (mag == '0)          lvl = CORR_W'(CORR_V0);
    else if (mag <= LIM_LO) lvl = CORR_W'(CORR_V1);
    else if (mag <= LIM_HI) lvl = CORR_W'(CORR_V2);
    else                    lvl = '0;
  end

  generate
    if (SIGNED_IN) begin : g_signed
      assign c = lvl;
    end else begin : g_unsigned
      assign c = d[IW-1] ? '0 : lvl;
    end
  endgenerate
endmodule

// File: rtl/dfc_cell.sv
module dfc_cell
  import dfc_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sel,
  input  logic          byp1,
  input  logic          byp2,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic [DW-1:0] v,
  input  logic [DW-1:0] w,
  output logic [DW-1:0] z
);
  localparam int AW = DW + 2;

  logic [DW-1:0]     sum1, sum2, base;
  logic [DW:0]       diff;
  logic [CORR_W-1:0] cu, cd, cs;
  logic [AW-1:0]     acc;
  logic              ovf;
  logic [DW-1:0]     z_d, z_q;

  dfc_sat_add #(.W(DW)) u_add1 (.a(x), .b(y), .s(sum1));
  dfc_sat_add #(.W(DW)) u_add2 (.a(v), .b(w), .s(sum2));

  assign diff = {sum1[DW-1], sum1} - {sum2[DW-1], sum2};

  dfc_corr_lut #(.IW(DW),   .SIGNED_IN(1'b0)) u_lut_u (.d(sum1), .c(cu));
  dfc_corr_lut #(.IW(DW+1), .SIGNED_IN(1'b1)) u_lut_d (.d(diff), .c(cd));
  dfc_corr_lut #(.IW(DW),   .SIGNED_IN(1'b1)) u_lut_s (.d(sum2), .c(cs));

  // next-state logic
  always_comb begin
    if (sel) base = sum2[DW-1] ? x : y;
    else     base = diff[DW] ? sum2 : sum1;
    acc = {{(AW-DW){base[DW-1]}}, base}
        + (byp1 ? '0 : {{(AW-CORR_W){1'b0}}, cu})
        + (byp2 ? '0 : {{(AW-CORR_W){1'b0}}, cd})
        - (sel  ? {{(AW-CORR_W){1'b0}}, cs} : '0);
    ovf = !((&acc[AW-1:DW-1]) || !(|acc[AW-1:DW-1]));
    if (ovf) z_d = acc[AW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else     z_d = acc[DW-1:0];
  end

  // result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  z_q <= '0;
    else if (en) z_q <= z_d;
  end

  assign z = z_q;
endmodule

// File: rtl/dfc_cell_chk.sv
module dfc_cell_chk #(
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          sel,
  input logic          byp1,
  input logic          byp2,
  input logic [DW-1:0] x,
  input logic [DW-1:0] y,
  input logic [DW-1:0] v,
  input logic [DW-1:0] w,
  input logic [DW-1:0] z
);
  localparam int HI = (1 << (DW-1)) - 1;
  localparam int LO = -(1 << (DW-1));

  int xi, yi, vi, wi, zi, s1, s2, mx, mn;

  always_comb begin
    xi = int'($signed(x));
    yi = int'($signed(y));
    vi = int'($signed(v));
    wi = int'($signed(w));
    zi = int'($signed(z));
    s1 = xi + yi;
    if (s1 > HI) s1 = HI;
    if (s1 < LO) s1 = LO;
    s2 = vi + wi;
    if (s2 > HI) s2 = HI;
    if (s2 < LO) s2 = LO;
    mx = (s1 > s2) ? s1 : s2;
    mn = (xi < yi) ? xi : yi;
  end

  // R2: a disabled edge keeps the result
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(z));

  // R8: trellis select with both corrections removed is a plain maximum
  assert_plain_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en && !sel && byp1 && byp2 |=> zi == $past(mx));

  // R5: trellis correction adds between 0 and 0.75
  assert_maxstar_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en && !sel && byp1 && !byp2 && mx < HI - 4 |=>
      (zi >= $past(mx)) && (zi <= $past(mx) + 3));

  // R6: check-node magnitude stays within 0.75 below the smaller operand
  assert_boxplus_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en && sel && !byp1 && byp2 && xi >= 0 && yi >= 0 && xi + yi <= HI &&
    vi == xi && wi == -yi |=>
      (zi <= $past(mn)) && (zi >= $past(mn) - 3));
endmodule

bind dfc_cell dfc_cell_chk #(.DW(DW)) u_dfc_cell_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sel(sel), .byp1(byp1), .byp2(byp2),
  .x(x), .y(y), .v(v), .w(w), .z(z)
);

// File: tb/test_dfc_cell.sv
module test_dfc_cell;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, sel, byp1, byp2;
  logic [8:0] x, y, v, w;
  logic [8:0] z;

  int    n_checks = 0;
  int    n_errors = 0;
  int    exp_z    = 0;
  string cur_tag  = "R1";
  bit    done     = 1'b0;

  dfc_cell i_dfc_cell (.clk(clk), .rst_n(rst_n), .en(en), .sel(sel),
    .byp1(byp1), .byp2(byp2), .x(x), .y(y), .v(v), .w(w), .z(z));

  always #10 clk = ~clk;

  function automatic int sat9(int a);
    if (a > 255)  return 255;
    if (a < -256) return -256;
    return a;
  endfunction

  function automatic int corr(int d);
    int m = (d < 0) ? -d : d;
    if (m == 0) return 3;
    if (m <= 3) return 2;
    if (m <= 8) return 1;
    return 0;
  endfunction

  function automatic int model(bit s, bit b1, bit b2, int xi, int yi, int vi, int wi);
    int s1 = sat9(xi + yi);
    int s2 = sat9(vi + wi);
    int d  = s1 - s2;
    int base, acc;
    if (s) base = (s2 < 0) ? xi : yi;
    else   base = (d < 0) ? s2 : s1;
    acc = base + (b1 ? 0 : ((s1 < 0) ? 0 : corr(s1)))
               + (b2 ? 0 : corr(d)) - (s ? corr(s2) : 0);
    return sat9(acc);
  endfunction

  task automatic check_now();
    int got = int'($signed(z));
    n_checks++;
    if (got != exp_z) begin
      n_errors++;
      $display("FAIL %s: z=%0d expected %0d", cur_tag, got, exp_z);
    end
  endtask

  // compare the previous result, then apply the next vector
  task automatic step(bit e, bit s, bit b1, bit b2, int xi, int yi, int vi, int wi, string tag);
    @(negedge clk);
    check_now();
    en = e; sel = s; byp1 = b1; byp2 = b2;
    x = 9'(xi); y = 9'(yi); v = 9'(vi); w = 9'(wi);
    if (e) exp_z = model(s, b1, b2, xi, yi, vi, wi);
    cur_tag = tag;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: z=%0d expected completion", int'($signed(z)));
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int seed = 7;
    rst_n = 1'b0; en = 1'b1; sel = 1'b0; byp1 = 1'b1; byp2 = 1'b0;
    x = 9'd50; y = 9'd50; v = 9'd1; w = 9'd1;
    repeat (3) @(negedge clk);
    // R1: reset holds zero, even with enable high
    check_now();
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_now();
    // R5 trellis, table boundaries of R4: d=8, 0, 2, 9, 3, 4
    step(1, 0, 1, 0, 10, 5, 3, 4, "R5");
    step(1, 0, 1, 0, 6, 6, 6, 6, "R4");
    step(1, 0, 1, 0, 7, 5, 6, 4, "R4");
    step(1, 0, 1, 0, 20, 0, 11, 0, "R4");
    step(1, 0, 1, 0, 0, 3, 0, 0, "R4");
    step(1, 0, 1, 0, 0, 0, 4, 0, "R4");
    step(1, 0, 1, 0, -40, 10, -20, -5, "R5");
    // R6 check-node: (5,3), (4,4), (0,9), (12,1)
    step(1, 1, 0, 1, 5, 3, 5, -3, "R6");
    step(1, 1, 0, 1, 4, 4, 4, -4, "R6");
    step(1, 1, 0, 1, 0, 9, 0, -9, "R6");
    step(1, 1, 0, 1, 12, 1, 12, -1, "R6");
    // R7: negative S1 gets no unsigned correction
    step(1, 1, 0, 1, -10, 2, 3, -1, "R7");
    step(1, 1, 0, 1, -1, 0, 0, 0, "R7");
    // R8: other control combinations
    step(1, 0, 0, 0, 2, 2, 1, 1, "R8");
    step(1, 0, 1, 1, 30, -2, 29, 0, "R8");
    step(1, 1, 1, 1, 8, 3, 2, 2, "R8");
    // R3: operand sums saturate
    step(1, 0, 1, 1, 200, 200, 0, 0, "R3");
    step(1, 0, 1, 1, -200, -200, -250, -100, "R3");
    step(1, 0, 1, 0, 200, 200, 255, 10, "R3");
    // R9: final sum saturates both ways
    step(1, 0, 1, 0, 255, 0, 255, 0, "R9");
    step(1, 1, 1, 1, -256, 0, -1, 0, "R9");
    // R2: disabled edges hold while operands change
    step(1, 0, 1, 0, 17, 4, 9, 9, "R2");
    step(0, 1, 0, 0, -100, 90, 3, 3, "R2");
    step(0, 0, 1, 1, 120, 120, 0, 0, "R2");
    step(1, 1, 0, 1, 7, 9, 7, -9, "R2");
    // R8: pseudo-random sweep of all modes and operands
    for (int i = 0; i < 400; i++) begin
      int r;
      seed = seed * 1103515245 + 12345;
      r = seed >>> 3;
      step(((r >> 20) & 7) != 0, r[0], r[1], r[2],
           ((r >> 3) & 511) - 256, ((r >> 12) & 511) - 256,
           (((r >> 5) ^ (r >> 17)) & 511) - 256, ((r >> 9) & 63) - 32, "R8");
    end
    @(negedge clk);
    check_now();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule